// File: doc/BRIEF.md
# Byte-Addressed Program Counter with Upper-Byte Holding Latches

This block keeps the instruction fetch address of a small processor core. The address is a byte address, but instructions are 16-bit words, so the least significant bit of the counter is always zero. Each instruction normally moves the counter forward by two. Control-transfer operations load a complete target in one step. Software can also compute a jump by writing the low byte of the counter.

Software never reaches the upper two fields of the counter directly. Two holding latches stand in for them. When software writes the low byte, both latch values move into the upper fields in the same cycle. When software reads the low byte, the current upper fields are copied back into the latches. This lets a program read the whole address, or build a new one, one byte at a time. Direct loads from call, relative-call, goto and branch operations neither use nor change the latches.

Top module: `pcw_top`

## Requirements
- R1: After a synchronous active-high reset the counter and both holding latches are zero.
- R2: With increment enabled and no load or low-byte write, the counter advances by 2 on each clock.
- R3: Incrementing from the highest aligned address (all ones except bit 0) wraps the counter to zero.
- R4: A direct-load strobe loads the target with bit 0 forced to 0 on the next clock.
- R5: A direct load leaves both holding latches unchanged.
- R6: A low-byte write sets the counter to {upper latch, middle latch, written byte with bit 0 cleared}. The middle latch fills bits 15:8 and the upper latch fills bits 20:16.
- R7: A low-byte read copies counter bits 15:8 into the middle latch and bits 20:16 into the upper latch.
- R8: The low-byte read data always shows counter bits 7:0, in the same cycle.
- R9: Priority within a cycle is direct load first, then low-byte write, then increment.
- R10: An explicit latch write takes priority over the copy made by a low-byte read in the same cycle. A latch that is not written still takes the copy. The upper latch takes write-data bits 4:0.
- R11: Counter bit 0 is zero at all times.
- R12: With no strobe active the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_en | input | 1 | Advance the counter by one instruction word |
| jmp_ld | input | 1 | Direct-load strobe for control transfers |
| jmp_tgt | input | 21 | Direct-load target address |
| lo_wr | input | 1 | Low-byte write strobe (computed jump) |
| lo_rd | input | 1 | Low-byte read strobe (captures upper fields) |
| lo_wdata | input | 8 | Data for a low-byte write |
| mid_latch_wr | input | 1 | Write strobe for the middle holding latch |
| up_latch_wr | input | 1 | Write strobe for the upper holding latch |
| latch_wdata | input | 8 | Data for the holding latches |
| pc_out | output | 21 | Current counter value |
| lo_rdata | output | 8 | Low byte of the counter |

## Verification
The bench builds the block with its default 21-bit width. This gives a 5-bit upper field, so both holding latches and the truncation of the upper latch write can be checked. A direct load to the highest aligned address brings the wrap point in reach after one increment. The hidden latch contents are brought out at the ports by following each read or load with a low-byte write.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

    localparam int BYTE_W     = 8;
    localparam int PC_W_DEF   = 21;
    localparam int MID_LSB    = 8;
    localparam int UP_LSB     = 16;
    localparam int WORD_BYTES = 2;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_JUMP = 2'd1,
        SRC_LOWR = 2'd2,
        SRC_SEQ  = 2'd3
    } pc_src_e;

    typedef struct packed {
        logic jmp;
        logic lowr;
        logic inc;
    } pc_req_t;

    function automatic pc_src_e pick_src(input pc_req_t req);
        if (req.jmp)       return SRC_JUMP;
        else if (req.lowr) return SRC_LOWR;
        else if (req.inc)  return SRC_SEQ;
        else               return SRC_HOLD;
    endfunction

endpackage

// File: rtl/pcw_latches.sv
module pcw_latches
    import pcw_pkg::*;
#(
    parameter int MID_W = 8,
    parameter int UP_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mid_wr,
    input  logic             up_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic             cap,
    input  logic [MID_W-1:0] cap_mid,
    input  logic [UP_W-1:0]  cap_up,
    output logic [MID_W-1:0] mid_q,
    output logic [UP_W-1:0]  up_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_q <= '0;
            up_q  <= '0;
        end else begin
            if (mid_wr)
                mid_q <= wdata[MID_W-1:0];
            else if (cap)
                mid_q <= cap_mid;

            if (up_wr)
                up_q <= wdata[UP_W-1:0];
            else if (cap)
                up_q <= cap_up;
        end
    end

endmodule

// File: rtl/pcw_next.sv
module pcw_next
    import pcw_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic [PC_W-1:0]       pc_q,
    input  pc_req_t               req,
    input  logic [PC_W-1:0]       jmp_tgt,
    input  logic [BYTE_W-1:0]     lo_wdata,
    input  logic [MID_LSB-1+BYTE_W-MID_LSB+MID_LSB-MID_LSB:0] mid_q,
    input  logic [PC_W-UP_LSB-1:0] up_q,
    output pc_src_e               src,
    output logic [PC_W-1:0]       pc_d
);

    localparam logic [PC_W-1:0] STEP = PC_W'(WORD_BYTES);

    logic [PC_W-1:0] seq_addr;
    logic [PC_W-1:0] jmp_addr;
    logic [PC_W-1:0] lowr_addr;

    always_comb begin
        seq_addr  = pc_q + STEP;
        jmp_addr  = {jmp_tgt[PC_W-1:1], 1'b0};
        lowr_addr = {up_q, mid_q, lo_wdata[BYTE_W-1:1], 1'b0};
        src       = pick_src(req);
        unique case (src)
            SRC_JUMP: pc_d = jmp_addr;
            SRC_LOWR: pc_d = lowr_addr;
            SRC_SEQ:  pc_d = seq_addr;
            default:  pc_d = pc_q;
        endcase
    end

endmodule

// File: rtl/pcw_top.sv
module pcw_top
    import pcw_pkg::*;
#(
    parameter int PC_W = PC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_en,
    input  logic              jmp_ld,
    input  logic [PC_W-1:0]   jmp_tgt,
    input  logic              lo_wr,
    input  logic              lo_rd,
    input  logic [BYTE_W-1:0] lo_wdata,
    input  logic              mid_latch_wr,
    input  logic              up_latch_wr,
    input  logic [BYTE_W-1:0] latch_wdata,
    output logic [PC_W-1:0]   pc_out,
    output logic [BYTE_W-1:0] lo_rdata
);

    localparam int MID_W = UP_LSB - MID_LSB;
    localparam int UP_W  = PC_W - UP_LSB;

    logic [PC_W-1:0]  pc_q;
    logic [PC_W-1:0]  pc_d;
    logic [MID_W-1:0] mid_q;
    logic [UP_W-1:0]  up_q;
    pc_req_t          req;
    pc_src_e          src;

    assign req = '{jmp: jmp_ld, lowr: lo_wr, inc: inc_en};

    pcw_latches #(.MID_W(MID_W), .UP_W(UP_W)) u_latches (
        .clk     (clk),
        .rst     (rst),
        .mid_wr  (mid_latch_wr),
        .up_wr   (up_latch_wr),
        .wdata   (latch_wdata),
        .cap     (lo_rd),
        .cap_mid (pc_q[UP_LSB-1:MID_LSB]),
        .cap_up  (pc_q[PC_W-1:UP_LSB]),
        .mid_q   (mid_q),
        .up_q    (up_q)
    );

    pcw_next #(.PC_W(PC_W)) u_next (
        .pc_q     (pc_q),
        .req      (req),
        .jmp_tgt  (jmp_tgt),
        .lo_wdata (lo_wdata),
        .mid_q    (mid_q),
        .up_q     (up_q),
        .src      (src),
        .pc_d     (pc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc_out   = pc_q;
    assign lo_rdata = pc_q[BYTE_W-1:0];

endmodule

// File: rtl/pcw_top_chk.sv
module pcw_top_chk
    import pcw_pkg::*;
#(
    parameter int PC_W = PC_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              inc_en,
    input logic              jmp_ld,
    input logic [PC_W-1:0]   jmp_tgt,
    input logic              lo_wr,
    input logic [BYTE_W-1:0] lo_wdata,
    input logic [PC_W-1:0]   pc_out
);

    p_align_r11: assert property (@(posedge clk) disable iff (rst)
        pc_out[0] == 1'b0);

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !jmp_ld && !lo_wr) |=> pc_out == PC_W'($past(pc_out) + PC_W'(2)));

    p_jump_r4: assert property (@(posedge clk) disable iff (rst)
        jmp_ld |=> pc_out == ($past(jmp_tgt) & ~PC_W'(1)));

    p_lowbyte_r6: assert property (@(posedge clk) disable iff (rst)
        (lo_wr && !jmp_ld) |=> pc_out[BYTE_W-1:0] == ($past(lo_wdata) & 8'hFE));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!inc_en && !jmp_ld && !lo_wr) |=> $stable(pc_out));

endmodule

bind pcw_top pcw_top_chk #(.PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .inc_en   (inc_en),
    .jmp_ld   (jmp_ld),
    .jmp_tgt  (jmp_tgt),
    .lo_wr    (lo_wr),
    .lo_wdata (lo_wdata),
    .pc_out   (pc_out)
);

// File: tb/tb_pcw_top.sv
`timescale 1ns/1ps
module tb_pcw_top;

    localparam int PC_W = 21;

    logic            clk = 1'b0;
    logic            rst;
    logic            inc_en, jmp_ld, lo_wr, lo_rd, mid_latch_wr, up_latch_wr;
    logic [PC_W-1:0] jmp_tgt;
    logic [7:0]      lo_wdata, latch_wdata;
    logic [PC_W-1:0] pc_out;
    logic [7:0]      lo_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pcw_top #(.PC_W(PC_W)) dut (
        .clk(clk), .rst(rst), .inc_en(inc_en), .jmp_ld(jmp_ld), .jmp_tgt(jmp_tgt),
        .lo_wr(lo_wr), .lo_rd(lo_rd), .lo_wdata(lo_wdata),
        .mid_latch_wr(mid_latch_wr), .up_latch_wr(up_latch_wr),
        .latch_wdata(latch_wdata), .pc_out(pc_out), .lo_rdata(lo_rdata)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        inc_en = 0; jmp_ld = 0; lo_wr = 0; lo_rd = 0;
        mid_latch_wr = 0; up_latch_wr = 0;
        jmp_tgt = '0; lo_wdata = '0; latch_wdata = '0;
    endtask

    task automatic tick();
        @(posedge clk); #2;
        idle();
    endtask

    task automatic jump(input logic [PC_W-1:0] t);
        jmp_ld = 1; jmp_tgt = t; tick();
    endtask

    task automatic low_write(input logic [7:0] d);
        lo_wr = 1; lo_wdata = d; tick();
    endtask

    task automatic t_reset();
        rst = 1; idle(); tick(); tick(); rst = 0;
        chk(pc_out == 0, "R1", pc_out, 0);
        low_write(8'h00);
        chk(pc_out == 0, "R1", pc_out, 0);
    endtask

    task automatic t_seq();
        jump('0);
        for (int i = 0; i < 3; i++) begin inc_en = 1; tick(); end
        chk(pc_out == 21'h6, "R2", pc_out, 6);
        chk(lo_rdata == 8'h06, "R8", lo_rdata, 6);
        tick();
        chk(pc_out == 21'h6, "R12", pc_out, 6);
    endtask

    task automatic t_wrap();
        jump(21'h1FFFFE);
        chk(pc_out == 21'h1FFFFE, "R4", pc_out, 21'h1FFFFE);
        inc_en = 1; tick();
        chk(pc_out == 0, "R3", pc_out, 0);
    endtask

    task automatic t_jump();
        jump(21'h12345);
        chk(pc_out == 21'h12344, "R4", pc_out, 21'h12344);
        chk(pc_out[0] == 1'b0, "R11", pc_out[0], 0);
    endtask

    task automatic t_latch();
        mid_latch_wr = 1; up_latch_wr = 1; latch_wdata = 8'h56; tick();
        up_latch_wr = 1; latch_wdata = 8'hEA; tick();
        low_write(8'h79);
        chk(pc_out == 21'h0A5678, "R6", pc_out, 21'h0A5678);
        jump(21'h0);
        low_write(8'h10);
        chk(pc_out == 21'h0A5610, "R5", pc_out, 21'h0A5610);
    endtask

    task automatic t_read();
        jump(21'h1B3C40);
        lo_rd = 1; #1;
        chk(lo_rdata == 8'h40, "R8", lo_rdata, 8'h40);
        tick();
        jump(21'h0);
        low_write(8'h02);
        chk(pc_out == 21'h1B3C02, "R7", pc_out, 21'h1B3C02);
    endtask

    task automatic t_prio();
        mid_latch_wr = 1; up_latch_wr = 1; latch_wdata = 8'h00; tick();
        jmp_ld = 1; jmp_tgt = 21'h00ABC0; lo_wr = 1; lo_wdata = 8'h44; inc_en = 1; tick();
        chk(pc_out == 21'h00ABC0, "R9", pc_out, 21'h00ABC0);
        lo_wr = 1; lo_wdata = 8'h44; inc_en = 1; tick();
        chk(pc_out == 21'h000044, "R9", pc_out, 21'h44);
    endtask

    task automatic t_latch_vs_read();
        jump(21'h0F0F00);
        lo_rd = 1; mid_latch_wr = 1; latch_wdata = 8'hAA; tick();
        jump(21'h0);
        low_write(8'h00);
        chk(pc_out == 21'h0FAA00, "R10", pc_out, 21'h0FAA00);
    endtask

    initial begin
        idle(); rst = 1;
        t_reset();
        t_seq();
        t_wrap();
        t_jump();
        t_latch();
        t_read();
        t_prio();
        t_latch_vs_read();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule